// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Control

This block resolves read-after-write dependences for the instruction sitting in the decode stage of a five-stage in-order integer pipeline. It takes the two source register numbers of that instruction and compares each against the destination register, valid flag and write-enable of the instructions now in execute, memory and writeback. For each operand it picks one of three values: the register file read, the execute-stage ALU result, or the memory-stage result. The two selected operands leave the block ready to be registered into execute.

A load in execute has no data yet, so a consumer directly behind it cannot be served by forwarding. In that case the block raises a stall. The pipeline uses that stall to hold fetch and decode and to put a bubble into execute. One cycle later the load sits in the memory stage and its data is forwarded from there. The block also holds the register file. Its read ports pass through the value being written in the same cycle, so the writeback stage needs no separate forwarding path. Register zero always reads as zero and never takes part in a dependence.

Top module: `fwd_stall_ctrl`

## Requirements
- R1: When neither the execute nor the memory producer is active with a destination equal to a nonzero source, that operand's select is 2'b00 (register file).
- R2: An active non-load execute producer whose destination equals a nonzero source gives select 2'b01, and the operand equals the execute result in the same cycle, with no stall.
- R3: An active memory producer whose destination equals a nonzero source, with no matching active execute producer, gives select 2'b10, and the operand equals the memory result.
- R4: When both the execute and memory producers match the same source, the execute producer wins (select 2'b01).
- R5: An active execute producer flagged as a load whose destination equals a nonzero source raises stall_o in the same cycle, and that operand's select reads 2'b01. A memory-stage load never stalls.
- R6: When writeback writes a nonzero register that decode reads in the same cycle, and no execute or memory producer matches, the operand equals the writeback data.
- R7: A source field of 0 always yields select 2'b00 and operand 0, and never contributes to a stall.
- R8: A producer counts as active only when both its valid flag and its write-enable are 1. Otherwise it neither forwards nor stalls.
- R9: Operands A and B are resolved independently. Each has its own select, and the stall is the OR of the two operands' load-use conditions.
- R10: A writeback to a nonzero register is stored at the clock edge and is read back in later cycles. The active-low reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, clears register file |
| dec_rs1_i | input | AW | Decode source register for operand A |
| dec_rs2_i | input | AW | Decode source register for operand B |
| ex_valid_i | input | 1 | Execute stage holds a live instruction |
| ex_we_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction is a load |
| ex_rd_i | input | AW | Execute destination register |
| ex_result_i | input | XLEN | ALU result at end of execute |
| mem_valid_i | input | 1 | Memory stage holds a live instruction |
| mem_we_i | input | 1 | Memory instruction writes a register |
| mem_rd_i | input | AW | Memory destination register |
| mem_result_i | input | XLEN | Result at end of memory stage (load data or ALU value) |
| wb_valid_i | input | 1 | Writeback stage holds a live instruction |
| wb_we_i | input | 1 | Writeback instruction writes a register |
| wb_rd_i | input | AW | Writeback destination register |
| wb_data_i | input | XLEN | Writeback data |
| sel_a_o | output | 2 | Operand A source: 00 register file, 01 execute, 10 memory |
| sel_b_o | output | 2 | Operand B source, same encoding |
| stall_o | output | 1 | Load-use interlock: hold fetch/decode, bubble into execute |
| opnd_a_o | output | XLEN | Resolved operand A |
| opnd_b_o | output | XLEN | Resolved operand B |

## Verification
The case that is hardest to reach is one where three producers overlap on the same register. An execute load, a memory-stage write and a writeback write all target one source, and only the load may win. At the same time the other operand must resolve on its own terms. The bench sweeps every pairing of four register numbers, including zero, across decode's two sources and all three destinations, and every activity mode of each producer, so these stacked overlaps arise many times. A reference register array, updated from the same writeback stimulus, supplies the values that the register-file path should return.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_EX  = 2'b01,
    SRC_MEM = 2'b10
  } opnd_src_e;
endpackage

// File: rtl/fwd_raw_detect.sv
module fwd_raw_detect
  import fwd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] rs_i,
  input  logic          ex_act_i,
  input  logic          ex_load_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          mem_act_i,
  input  logic [AW-1:0] mem_rd_i,
  output opnd_src_e     src_o,
  output logic          stall_o
);
  logic rs_live, ex_hit, mem_hit;

  assign rs_live = (rs_i != '0);
  assign ex_hit  = rs_live && ex_act_i  && (ex_rd_i  == rs_i);
  assign mem_hit = rs_live && mem_act_i && (mem_rd_i == rs_i);

  // youngest producer first
  always_comb begin
    if (ex_hit)       src_o = SRC_EX;
    else if (mem_hit) src_o = SRC_MEM;
    else              src_o = SRC_RF;
  end

  assign stall_o = ex_hit && ex_load_i;
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
  import fwd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  opnd_src_e       src_i,
  input  logic [XLEN-1:0] rf_i,
  input  logic [XLEN-1:0] ex_i,
  input  logic [XLEN-1:0] mem_i,
  output logic [XLEN-1:0] opnd_o
);
  always_comb begin
    unique case (src_i)
      SRC_EX:  opnd_o = ex_i;
      SRC_MEM: opnd_o = mem_i;
      default: opnd_o = rf_i;
    endcase
  end
endmodule

// File: rtl/fwd_regfile.sv
module fwd_regfile #(
  parameter int XLEN   = 32,
  parameter int NREGS  = 32,
  parameter int NREAD  = 2,
  localparam int AW    = $clog2(NREGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [AW-1:0]              wa_i,
  input  logic [XLEN-1:0]            wd_i,
  input  logic [NREAD-1:0][AW-1:0]   ra_i,
  output logic [NREAD-1:0][XLEN-1:0] rd_o
);
  logic [XLEN-1:0] regs_q [NREGS];
  logic            wr_live;

  assign wr_live = we_i && (wa_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (wr_live) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  for (genvar p = 0; p < NREAD; p++) begin : g_rport
    always_comb begin
      if (ra_i[p] == '0)                   rd_o[p] = '0;
      else if (wr_live && wa_i == ra_i[p]) rd_o[p] = wd_i;  // same-cycle write shows through
      else                                 rd_o[p] = regs_q[ra_i[p]];
    end
  end
endmodule

// File: rtl/fwd_stall_ctrl.sv
module fwd_stall_ctrl
  import fwd_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   dec_rs1_i,
  input  logic [AW-1:0]   dec_rs2_i,
  input  logic            ex_valid_i,
  input  logic            ex_we_i,
  input  logic            ex_load_i,
  input  logic [AW-1:0]   ex_rd_i,
  input  logic [XLEN-1:0] ex_result_i,
  input  logic            mem_valid_i,
  input  logic            mem_we_i,
  input  logic [AW-1:0]   mem_rd_i,
  input  logic [XLEN-1:0] mem_result_i,
  input  logic            wb_valid_i,
  input  logic            wb_we_i,
  input  logic [AW-1:0]   wb_rd_i,
  input  logic [XLEN-1:0] wb_data_i,
  output logic [1:0]      sel_a_o,
  output logic [1:0]      sel_b_o,
  output logic            stall_o,
  output logic [XLEN-1:0] opnd_a_o,
  output logic [XLEN-1:0] opnd_b_o
);
  localparam int NOPND = 2;

  logic                       ex_act, mem_act, wb_act;
  logic [NOPND-1:0][AW-1:0]   rs;
  logic [NOPND-1:0][XLEN-1:0] rf_rd;
  logic [NOPND-1:0][XLEN-1:0] opnd;
  opnd_src_e                  src [NOPND];
  logic [NOPND-1:0]           stall_v;

  assign ex_act  = ex_valid_i  && ex_we_i;
  assign mem_act = mem_valid_i && mem_we_i;
  assign wb_act  = wb_valid_i  && wb_we_i;
  assign rs[0]   = dec_rs1_i;
  assign rs[1]   = dec_rs2_i;

  fwd_regfile #(.XLEN(XLEN), .NREGS(NREGS), .NREAD(NOPND)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wb_act),
    .wa_i   (wb_rd_i),
    .wd_i   (wb_data_i),
    .ra_i   (rs),
    .rd_o   (rf_rd)
  );

  for (genvar i = 0; i < NOPND; i++) begin : g_opnd
    fwd_raw_detect #(.AW(AW)) u_det (
      .rs_i      (rs[i]),
      .ex_act_i  (ex_act),
      .ex_load_i (ex_load_i),
      .ex_rd_i   (ex_rd_i),
      .mem_act_i (mem_act),
      .mem_rd_i  (mem_rd_i),
      .src_o     (src[i]),
      .stall_o   (stall_v[i])
    );
    fwd_operand_mux #(.XLEN(XLEN)) u_mux (
      .src_i  (src[i]),
      .rf_i   (rf_rd[i]),
      .ex_i   (ex_result_i),
      .mem_i  (mem_result_i),
      .opnd_o (opnd[i])
    );
  end

  assign sel_a_o  = src[0];
  assign sel_b_o  = src[1];
  assign opnd_a_o = opnd[0];
  assign opnd_b_o = opnd[1];
  assign stall_o  = |stall_v;
endmodule

// File: rtl/fwd_stall_ctrl_chk.sv
module fwd_stall_ctrl_chk #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [AW-1:0]   dec_rs1_i,
  input logic [AW-1:0]   dec_rs2_i,
  input logic            ex_valid_i,
  input logic            ex_we_i,
  input logic            ex_load_i,
  input logic [AW-1:0]   ex_rd_i,
  input logic [XLEN-1:0] ex_result_i,
  input logic            mem_valid_i,
  input logic            mem_we_i,
  input logic [AW-1:0]   mem_rd_i,
  input logic [XLEN-1:0] mem_result_i,
  input logic            wb_valid_i,
  input logic            wb_we_i,
  input logic [AW-1:0]   wb_rd_i,
  input logic [XLEN-1:0] wb_data_i,
  input logic [1:0]      sel_a_o,
  input logic [1:0]      sel_b_o,
  input logic            stall_o,
  input logic [XLEN-1:0] opnd_a_o,
  input logic [XLEN-1:0] opnd_b_o
);
  logic ex_a, ex_b, mem_a, mem_b;
  assign ex_a  = ex_valid_i && ex_we_i && dec_rs1_i != '0 && ex_rd_i == dec_rs1_i;
  assign ex_b  = ex_valid_i && ex_we_i && dec_rs2_i != '0 && ex_rd_i == dec_rs2_i;
  assign mem_a = mem_valid_i && mem_we_i && dec_rs1_i != '0 && mem_rd_i == dec_rs1_i;
  assign mem_b = mem_valid_i && mem_we_i && dec_rs2_i != '0 && mem_rd_i == dec_rs2_i;

  p_src_none_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ex_a && !mem_a) |-> sel_a_o == 2'b00);

  p_ex_fwd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_a && !ex_load_i) |-> (sel_a_o == 2'b01 && opnd_a_o == ex_result_i));

  p_mem_fwd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_b && !ex_b) |-> (sel_b_o == 2'b10 && opnd_b_o == mem_result_i));

  p_ex_over_mem_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_a && mem_a) |-> sel_a_o == 2'b01);

  p_load_use_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ex_a || ex_b) && ex_load_i) |-> stall_o);

  p_no_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((ex_a || ex_b) && ex_load_i) |-> !stall_o);

  p_x0_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_rs1_i == '0) |-> (sel_a_o == 2'b00 && opnd_a_o == '0));

  p_wb_persist_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && wb_we_i && wb_rd_i != '0) |=>
      ((dec_rs1_i == $past(wb_rd_i) && !ex_a && !mem_a
        && !(wb_valid_i && wb_we_i && wb_rd_i == dec_rs1_i))
       |-> opnd_a_o == $past(wb_data_i)));
endmodule

bind fwd_stall_ctrl fwd_stall_ctrl_chk #(.XLEN(XLEN), .NREGS(NREGS)) u_chk (.*);

// File: tb/fwd_stall_ctrl_tb.sv
module fwd_stall_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int NREGS = 32;
  localparam int AW = $clog2(NREGS);

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [AW-1:0]   dec_rs1, dec_rs2, ex_rd, mem_rd, wb_rd;
  logic            ex_valid, ex_we, ex_load, mem_valid, mem_we, wb_valid, wb_we;
  logic [XLEN-1:0] ex_result, mem_result, wb_data;
  logic [1:0]      sel_a, sel_b;
  logic            stall;
  logic [XLEN-1:0] opnd_a, opnd_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [XLEN-1:0] ref_rf [NREGS];

  always #(CLK_PERIOD/2) clk = ~clk;

  fwd_stall_ctrl #(.XLEN(XLEN), .NREGS(NREGS)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .dec_rs1_i(dec_rs1), .dec_rs2_i(dec_rs2),
    .ex_valid_i(ex_valid), .ex_we_i(ex_we), .ex_load_i(ex_load),
    .ex_rd_i(ex_rd), .ex_result_i(ex_result),
    .mem_valid_i(mem_valid), .mem_we_i(mem_we), .mem_rd_i(mem_rd),
    .mem_result_i(mem_result),
    .wb_valid_i(wb_valid), .wb_we_i(wb_we), .wb_rd_i(wb_rd), .wb_data_i(wb_data),
    .sel_a_o(sel_a), .sel_b_o(sel_b), .stall_o(stall),
    .opnd_a_o(opnd_a), .opnd_b_o(opnd_b)
  );

  task automatic chk(input bit ok, input string tag, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ex_valid = 0; ex_we = 0; ex_load = 0; ex_rd = '0; ex_result = '0;
    mem_valid = 0; mem_we = 0; mem_rd = '0; mem_result = '0;
    wb_valid = 0; wb_we = 0; wb_rd = '0; wb_data = '0;
    dec_rs1 = '0; dec_rs2 = '0;
  endtask

  // expected resolution of one operand
  task automatic check_opnd(input logic [AW-1:0] rs, input logic [1:0] sel_act,
                            input logic [XLEN-1:0] val_act, input string side);
    bit ex_on, mem_on, wb_on, ex_m, mem_m, wb_m, stale;
    logic [1:0] es;
    logic [XLEN-1:0] ev;
    string tag;
    ex_on  = ex_valid && ex_we;
    mem_on = mem_valid && mem_we;
    wb_on  = wb_valid && wb_we;
    ex_m   = rs != 0 && ex_on && ex_rd == rs;
    mem_m  = rs != 0 && mem_on && mem_rd == rs;
    wb_m   = rs != 0 && wb_on && wb_rd == rs;
    stale  = rs != 0 && ((!ex_on && ex_rd == rs) || (!mem_on && mem_rd == rs)
                         || (!wb_on && wb_rd == rs));
    if (ex_m)       begin es = 2'b01; ev = ex_result;  end
    else if (mem_m) begin es = 2'b10; ev = mem_result; end
    else begin
      es = 2'b00;
      ev = (rs == 0) ? '0 : (wb_m ? wb_data : ref_rf[rs]);
    end
    if (rs == 0)                tag = "R7";
    else if (ex_m && ex_load)   tag = "R5";
    else if (ex_m && mem_m)     tag = "R4";
    else if (ex_m)              tag = "R2";
    else if (mem_m)             tag = "R3";
    else if (wb_m)              tag = "R6";
    else if (stale)             tag = "R8";
    else                        tag = "R1";
    chk(sel_act == es, {tag, " sel ", side}, XLEN'(sel_act), XLEN'(es));
    chk(val_act == ev, {(tag == "R1") ? "R10" : tag, " opnd ", side}, val_act, ev);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seq = 0;
    idle();
    for (int i = 0; i < NREGS; i++) ref_rf[i] = '0;
    #(CLK_PERIOD * 2);
    @(negedge clk); rst_ni = 1;

    // R10: reset state, every register reads zero, nothing forwarded
    for (int r = 0; r < NREGS; r++) begin
      @(negedge clk);
      dec_rs1 = AW'(r); dec_rs2 = AW'(NREGS - 1 - r);
      #1;
      chk(opnd_a == '0 && opnd_b == '0, "R10 reset value", opnd_a | opnd_b, '0);
      chk(stall == 1'b0, "R1 no stall after reset", XLEN'(stall), 0);
    end

    // R9: A from execute, B from memory in the same cycle
    @(negedge clk);
    idle();
    dec_rs1 = 5'd6; dec_rs2 = 5'd9;
    ex_valid = 1; ex_we = 1; ex_rd = 5'd6; ex_result = 32'h1111_0006;
    mem_valid = 1; mem_we = 1; mem_rd = 5'd9; mem_result = 32'h2222_0009;
    #1;
    chk(sel_a == 2'b01 && sel_b == 2'b10, "R9 split sel", {28'd0, sel_a, sel_b}, 32'h6);
    chk(opnd_a == 32'h1111_0006 && opnd_b == 32'h2222_0009, "R9 split opnd",
        opnd_a ^ opnd_b, 32'h3333_000f);
    // R5 only on B
    ex_load = 1; ex_rd = 5'd9; #1;
    chk(stall == 1'b1 && sel_a == 2'b00, "R9 stall from B only", {31'd0, stall}, 1);

    // sweep: all register pairings over {0..3} and producer modes
    for (int ec = 0; ec < 4; ec++)
      for (int mc = 0; mc < 3; mc++)
        for (int wc = 0; wc < 3; wc++)
          for (int code = 0; code < 1024; code++) begin
            bit exp_stall;
            @(negedge clk);
            seq++;
            dec_rs1 = AW'(code & 3);
            dec_rs2 = AW'((code >> 2) & 3);
            ex_rd   = AW'((code >> 4) & 3);
            mem_rd  = AW'((code >> 6) & 3);
            wb_rd   = AW'((code >> 8) & 3);
            ex_valid = (ec != 0); ex_we = (ec != 1); ex_load = (ec == 3);
            mem_valid = (mc != 0); mem_we = (mc != 1);
            wb_valid = (wc != 0); wb_we = (wc != 1);
            ex_result  = 32'hE000_0000 | XLEN'(seq);
            mem_result = 32'hA000_0000 | XLEN'(seq);
            wb_data    = 32'hB000_0000 | XLEN'(seq);
            #1;
            check_opnd(dec_rs1, sel_a, opnd_a, "A");
            check_opnd(dec_rs2, sel_b, opnd_b, "B");
            exp_stall = ex_valid && ex_we && ex_load && ex_rd != 0 &&
                        (ex_rd == dec_rs1 || ex_rd == dec_rs2);
            chk(stall == exp_stall, "R5 stall", XLEN'(stall), XLEN'(exp_stall));
            @(posedge clk);
            if (wb_valid && wb_we && wb_rd != 0) ref_rf[wb_rd] = wb_data;
          end

    // R10: reset clears stored value
    @(negedge clk);
    idle();
    rst_ni = 0; #1; rst_ni = 1;
    dec_rs1 = 5'd1; dec_rs2 = 5'd3; #1;
    chk(opnd_a == '0 && opnd_b == '0, "R10 reset clears", opnd_a | opnd_b, '0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule